// File: doc/BRIEF.md
# Auto-Refresh and Self-Refresh Sequencer

This block sits beside the main command arbiter of a four-bank DDR SDRAM controller and keeps the memory refreshed. A free-running interval timer adds one owed refresh every refresh period. The debt may stand while traffic is heavy, but it never grows past eight. The sequencer raises a request whenever something is owed. It raises an urgent flag once the debt is full. It waits for the arbiter's grant before it takes the command bus.

Once granted, it closes any open rows with a precharge-all. It then issues auto-refresh commands back to back until nothing is owed, spacing them by the refresh recovery time, and hands the bus back. The same path also puts the device into self refresh while a sleep request is held. When the request drops, the sequencer wakes the device with clock enable raised under deselect. It keeps the bus until non-read commands are safe again, and it reports separately when reads become legal.

All nanosecond limits are turned into whole cycles by rounding up against a clock-period parameter. At the default 6 ns clock this gives 2600 cycles per refresh interval, 3 cycles of precharge wait, 12 of refresh recovery, 13 of non-read wake wait, and a 200-cycle read wait.

The states are ST_IDLE, ST_PREALL, ST_PRE_WAIT, ST_AREF, ST_AREF_WAIT, ST_SR_ENTER, ST_SR_HOLD, ST_SR_WAKE and ST_WAKE_WAIT. They move as follows:
- From ST_IDLE, a grant that meets a raised request goes to ST_PREALL if any bank is open, and otherwise takes the "clean" choice.
- The clean choice is ST_SR_ENTER if sleep is requested, else ST_AREF if debt is non-zero, else ST_IDLE.
- ST_PREALL always goes to ST_PRE_WAIT, which takes the clean choice when its wait expires.
- ST_AREF always goes to ST_AREF_WAIT, which takes the clean choice when its wait expires.
- ST_SR_ENTER always goes to ST_SR_HOLD, which stays there until the sleep request drops and then goes to ST_SR_WAKE.
- ST_SR_WAKE always goes to ST_WAKE_WAIT, which returns to ST_IDLE when its wait expires.

Top module: `rfsh_sched`

## Requirements
- R1: Out of reset the block drives deselect with cke high (cke,cs_n,ras_n,cas_n,we_n,a10 = 1,1,1,1,1,0). Debt is 0, arb_req, arb_urgent and bus_own are low, and rd_ok is high.
- R2: While awake, debt increases by one at the end of every REFI_CYC-th cycle (2600 at defaults), counted from reset or from the end of a wake wait.
- R3: Debt never exceeds 8. Extra intervals at 8 are dropped, and arb_urgent is high exactly while debt is 8.
- R4: arb_req is high only in ST_IDLE while debt is non-zero or sr_req is high. A grant sampled with arb_req high makes bus_own rise on the next cycle. Whenever bus_own is low, the command lines show deselect with cke high.
- R5: If any bit of bank_open is set when the grant is taken, the first command is precharge-all (1,0,0,1,0,1), and the following refresh comes exactly TRP_CYC (3) cycles later.
- R6: An auto refresh is driven as (1,0,0,0,1,0), and each one lowers debt by one.
- R7: Owed refreshes drain back to back, TRFC_CYC (12) cycles apart. The bus is released TRFC_CYC cycles after the last one, once debt is zero.
- R8: Self-refresh entry is driven as (0,0,0,0,1,0) and clears the debt. After it, cke stays low under deselect, and the interval timer is held, for as long as sr_req stays high.
- R9: When sr_req drops, cke returns high under deselect, and bus_own falls XSNR_CYC (13) cycles after that first high-cke cycle.
- R10: rd_ok is low from the cycle after self-refresh entry until XSRD_CYC (200) cycles after the first high-cke cycle of the wake.
- R11: A grant while arb_req is low is ignored, and bus_own stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_open | input | BANKS | One bit per bank with an open row |
| sr_req | input | 1 | Level request to sleep in self refresh |
| arb_gnt | input | 1 | Arbiter hands over the command bus |
| arb_req | output | 1 | Sequencer wants the bus |
| arb_urgent | output | 1 | Debt is full, refresh must not wait |
| bus_own | output | 1 | Sequencer is driving the command bus |
| rd_ok | output | 1 | Read commands are allowed |
| debt | output | DEBT_W | Number of refreshes owed |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | All-banks flag for precharge |

## Verification
The sequencer is first granted a single owed refresh with all banks closed, which shows that no precharge is inserted needlessly. It is then left ungranted until the debt fills and stays full, and granted with two banks open, which separates the precharge spacing from the refresh spacing and shows that the whole debt drains in one ownership. Self refresh is tried both with an open bank and with all banks closed; this tells the non-read wake wait from the much longer read wait. A stray grant with nothing owed shows that ownership follows the request and not the grant alone.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } dcmd_t;

    localparam dcmd_t CMD_DESEL  = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam dcmd_t CMD_PREALL = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam dcmd_t CMD_AREF   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam dcmd_t CMD_SRENT  = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam dcmd_t CMD_SLEEP  = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREALL,
        ST_PRE_WAIT,
        ST_AREF,
        ST_AREF_WAIT,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_WAKE,
        ST_WAKE_WAIT
    } rs_state_t;

    function automatic int ps_to_cyc(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/rfsh_tick.sv
`timescale 1ns/1ps
module rfsh_tick #(
    parameter int PERIOD = 2600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    assign tick = !hold && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_debt.sv
`timescale 1ns/1ps
module rfsh_debt #(
    parameter int MAX = 8,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         full
);
    localparam logic [W-1:0] TOP = W'(MAX);

    assign full = (count == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (!full) count <= count + 1'b1;
                2'b01: if (count != '0) count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_down.sv
`timescale 1ns/1ps
module rfsh_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_sched.sv
`timescale 1ns/1ps
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int CLK_PS   = 6000,
    parameter int REFI_PS  = 15600000,
    parameter int TRP_PS   = 18000,
    parameter int TRFC_PS  = 72000,
    parameter int XSNR_PS  = 75000,
    parameter int XSRD_CYC = 200,
    parameter int DEBT_MAX = 8,
    parameter int BANKS    = 4,
    parameter int DEBT_W   = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANKS-1:0]  bank_open,
    input  logic              sr_req,
    input  logic              arb_gnt,
    output logic              arb_req,
    output logic              arb_urgent,
    output logic              bus_own,
    output logic              rd_ok,
    output logic [DEBT_W-1:0] debt,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              a10
);
    localparam int REFI_CYC = ps_to_cyc(REFI_PS, CLK_PS);
    localparam int TRP_CYC  = ps_to_cyc(TRP_PS, CLK_PS);
    localparam int TRFC_CYC = ps_to_cyc(TRFC_PS, CLK_PS);
    localparam int XSNR_CYC = ps_to_cyc(XSNR_PS, CLK_PS);
    localparam int WMAX_A   = (TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC;
    localparam int WMAX     = (XSNR_CYC > WMAX_A) ? XSNR_CYC : WMAX_A;
    localparam int WAIT_W   = $clog2(WMAX + 1);
    localparam int RD_W     = $clog2(XSRD_CYC + 1);

    rs_state_t state, nxt, clean_nxt;
    dcmd_t     cmd;

    logic              tick, in_sr, debt_full;
    logic              wt_load, wt_zero, rd_load;
    logic [WAIT_W-1:0] wt_val;

    // interval timer, frozen while the device refreshes itself
    assign in_sr = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) ||
                   (state == ST_SR_WAKE)  || (state == ST_WAKE_WAIT);

    rfsh_tick #(.PERIOD(REFI_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (in_sr),
        .tick  (tick)
    );

    rfsh_debt #(.MAX(DEBT_MAX), .W(DEBT_W)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_SR_ENTER),
        .inc   (tick),
        .dec   (state == ST_AREF),
        .count (debt),
        .full  (debt_full)
    );

    // shared wait timer for precharge, refresh recovery and wake
    always_comb begin
        wt_load = 1'b0;
        wt_val  = '0;
        unique case (state)
            ST_PREALL: begin wt_load = 1'b1; wt_val = WAIT_W'(TRP_CYC - 2);  end
            ST_AREF:   begin wt_load = 1'b1; wt_val = WAIT_W'(TRFC_CYC - 2); end
            ST_SR_WAKE: begin wt_load = 1'b1; wt_val = WAIT_W'(XSNR_CYC - 2); end
            default: ;
        endcase
    end

    rfsh_down #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .zero     (wt_zero)
    );

    // read hold: reloaded through entry, sleep and the wake cycle
    assign rd_load = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) || (state == ST_SR_WAKE);

    rfsh_down #(.W(RD_W)) u_rdhold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_load),
        .load_val (RD_W'(XSRD_CYC - 1)),
        .zero     (rd_ok)
    );

    assign arb_req    = (state == ST_IDLE) && (sr_req || (debt != '0));
    assign arb_urgent = debt_full;

    // where to go once every bank is known to be closed
    always_comb begin
        if (sr_req)            clean_nxt = ST_SR_ENTER;
        else if (debt != '0)   clean_nxt = ST_AREF;
        else                   clean_nxt = ST_IDLE;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (arb_req && arb_gnt) nxt = (|bank_open) ? ST_PREALL : clean_nxt;
            ST_PREALL:    nxt = ST_PRE_WAIT;
            ST_PRE_WAIT:  if (wt_zero) nxt = clean_nxt;
            ST_AREF:      nxt = ST_AREF_WAIT;
            ST_AREF_WAIT: if (wt_zero) nxt = clean_nxt;
            ST_SR_ENTER:  nxt = ST_SR_HOLD;
            ST_SR_HOLD:   if (!sr_req) nxt = ST_SR_WAKE;
            ST_SR_WAKE:   nxt = ST_WAKE_WAIT;
            ST_WAKE_WAIT: if (wt_zero) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        cmd     = CMD_DESEL;
        bus_own = 1'b1;
        unique case (state)
            ST_IDLE:      bus_own = 1'b0;
            ST_PREALL:    cmd = CMD_PREALL;
            ST_AREF:      cmd = CMD_AREF;
            ST_SR_ENTER:  cmd = CMD_SRENT;
            ST_SR_HOLD:   cmd = CMD_SLEEP;
            ST_PRE_WAIT, ST_AREF_WAIT, ST_SR_WAKE, ST_WAKE_WAIT: cmd = CMD_DESEL;
            default: begin cmd = CMD_DESEL; bus_own = 1'b0; end
        endcase
    end

    assign cke   = cmd.cke;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign a10   = cmd.a10;

endmodule

// File: rtl/rfsh_sched_chk.sv
`timescale 1ns/1ps
module rfsh_sched_chk #(
    parameter int DEBT_MAX = 8,
    parameter int DEBT_W   = 4,
    parameter int TRFC_CYC = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              a10,
    input logic              bus_own,
    input logic              rd_ok,
    input logic [DEBT_W-1:0] debt
);
    logic       is_ref, is_pre;
    logic [7:0] since_ref;
    logic       seen_ref;

    assign is_ref = cke && !cs_n && !ras_n && !cas_n && we_n;
    assign is_pre = cke && !cs_n && !ras_n && cas_n && !we_n && a10;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ref <= '0;
            seen_ref  <= 1'b0;
        end else if (is_ref) begin
            since_ref <= 8'd1;
            seen_ref  <= 1'b1;
        end else if (since_ref != 8'hFF) begin
            since_ref <= since_ref + 1'b1;
        end
    end

    p_debt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DEBT_WIDTH_MAX);

    localparam logic [DEBT_W-1:0] DEBT_WIDTH_MAX = DEBT_W'(DEBT_MAX);

    p_desel_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (cke && cs_n));

    p_pre_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (!$past(is_pre) && !$past(is_pre, 2)));

    p_ref_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> (debt <= $past(debt)));

    p_ref_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && seen_ref) |-> (since_ref >= 8'(TRFC_CYC)));

    p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

    p_wake_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cs_n);

    p_read_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cke) |-> !rd_ok);

endmodule

bind rfsh_sched rfsh_sched_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .a10     (a10),
    .bus_own (bus_own),
    .rd_ok   (rd_ok),
    .debt    (debt)
);

// File: tb/sim_rfsh_sched.sv
`timescale 1ns/1ps
module sim_rfsh_sched;

    localparam int REFI  = 2600;
    localparam int TRP   = 3;
    localparam int TRFC  = 12;
    localparam int XSNR  = 13;
    localparam int XSRD  = 200;
    localparam int DMAX  = 8;

    localparam logic [5:0] K_DESEL = 6'b111110;
    localparam logic [5:0] K_PRE   = 6'b100101;
    localparam logic [5:0] K_REF   = 6'b100010;
    localparam logic [5:0] K_SRE   = 6'b000010;
    localparam logic [5:0] K_SLEEP = 6'b011110;

    // model phases
    localparam int M_IDLE = 0, M_PRE = 1, M_PW = 2, M_REF = 3, M_RW = 4,
                   M_SRE = 5, M_SELF = 6, M_SRX = 7, M_XW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bank_open = 4'b0;
    logic       sr_req = 1'b0;
    logic       arb_gnt = 1'b0;
    logic       arb_req, arb_urgent, bus_own, rd_ok;
    logic [3:0] debt;
    logic       cke, cs_n, ras_n, cas_n, we_n, a10;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rfsh_sched u0 (
        .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .sr_req(sr_req),
        .arb_gnt(arb_gnt), .arb_req(arb_req), .arb_urgent(arb_urgent),
        .bus_own(bus_own), .rd_ok(rd_ok), .debt(debt), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10)
    );

    function automatic logic [5:0] cmd_now();
        return {cke, cs_n, ras_n, cas_n, we_n, a10};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_k, m_d, m_tc, m_rd, m_due, nk, nd, clean;
    bit insr, tk;

    function automatic logic [5:0] m_cmd(input int k);
        case (k)
            M_PRE:  return K_PRE;
            M_REF:  return K_REF;
            M_SRE:  return K_SRE;
            M_SELF: return K_SLEEP;
            default: return K_DESEL;
        endcase
    endfunction

    function automatic string m_tag(input int k);
        case (k)
            M_PRE:          return "R5";
            M_REF:          return "R6";
            M_SRE, M_SELF:  return "R8";
            M_SRX, M_XW:    return "R9";
            default:        return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_k = M_IDLE; m_d = 0; m_tc = 0; m_rd = 0; m_due = 0;
        end else begin
            insr = (m_k >= M_SRE);
            tk   = !insr && (m_tc == REFI - 1);
            m_tc = (insr || tk) ? 0 : m_tc + 1;
            if (m_k == M_SRE || m_k == M_SELF || m_k == M_SRX) m_rd = XSRD - 1;
            else if (m_rd > 0) m_rd = m_rd - 1;
            clean = sr_req ? M_SRE : ((m_d > 0) ? M_REF : M_IDLE);
            nk = m_k;
            case (m_k)
                M_IDLE: if (arb_gnt && (m_d > 0 || sr_req)) nk = (bank_open != 0) ? M_PRE : clean;
                M_PRE:  begin nk = M_PW; m_due = cyc + TRP; end
                M_PW:   if (cyc + 1 == m_due) nk = clean;
                M_REF:  begin nk = M_RW; m_due = cyc + TRFC; end
                M_RW:   if (cyc + 1 == m_due) nk = clean;
                M_SRE:  nk = M_SELF;
                M_SELF: if (!sr_req) nk = M_SRX;
                M_SRX:  begin nk = M_XW; m_due = cyc + XSNR; end
                M_XW:   if (cyc + 1 == m_due) nk = M_IDLE;
                default: nk = M_IDLE;
            endcase
            if (m_k == M_SRE) nd = 0;
            else if (tk && m_k != M_REF) nd = (m_d < DMAX) ? m_d + 1 : m_d;
            else if (!tk && m_k == M_REF) nd = m_d - 1;
            else nd = m_d;
            m_k = nk;
            m_d = nd;
        end
        cyc++;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cmd_now() == m_cmd(m_k), m_tag(m_k), cmd_now(), m_cmd(m_k));
            chk(bus_own == (m_k != M_IDLE), "R4", bus_own, m_k != M_IDLE);
            chk(arb_req == (m_k == M_IDLE && (m_d > 0 || sr_req)), "R4", arb_req,
                m_k == M_IDLE && (m_d > 0 || sr_req));
            chk(arb_urgent == (m_d == DMAX), "R3", arb_urgent, m_d == DMAX);
            chk(int'(debt) == m_d, "R2", debt, m_d);
            chk(rd_ok == (m_rd == 0), "R10", rd_ok, m_rd == 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic grant_pulse();
        step(); arb_gnt = 1'b1;
        step(); arb_gnt = 1'b0;
    endtask

    task automatic wait_code(input logic [5:0] code, input int lim, output int at);
        at = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (cmd_now() == code) begin at = cyc; break; end
        end
    endtask

    initial begin
        #(4 * 199000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int p, r1, r2, last, nref, rel, x, rd;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(cmd_now() == K_DESEL, "R1", cmd_now(), K_DESEL);
        chk(debt == 0 && !arb_req && !arb_urgent && !bus_own, "R1", debt, 0);
        chk(rd_ok == 1'b1, "R1", rd_ok, 1);

        // R11: grant with nothing owed
        grant_pulse();
        @(negedge clk); chk(!bus_own, "R11", bus_own, 0);
        @(negedge clk); chk(!bus_own, "R11", bus_own, 0);

        // R2: first interval adds one refresh
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (debt != 0) break;
        end
        chk(debt == 1, "R2", debt, 1);

        // R6: single refresh, banks closed, no precharge
        grant_pulse();
        wait_code(K_REF, 10, r1);
        chk(r1 >= 0, "R6", r1, 0);
        repeat (TRFC) @(negedge clk);
        chk(debt == 0 && !bus_own, "R6", debt, 0);

        // R3: let the debt fill and stay full
        for (int i = 0; i < 25000; i++) begin
            @(negedge clk);
            if (arb_urgent) break;
        end
        chk(debt == DMAX && arb_urgent, "R3", debt, DMAX);
        repeat (REFI + 100) @(negedge clk);
        chk(debt == DMAX, "R3", debt, DMAX);

        // R5 and R7: drain with open banks
        step(); bank_open = 4'b0110;
        grant_pulse();
        wait_code(K_PRE, 10, p);
        wait_code(K_REF, 10, r1);
        chk(r1 - p == TRP, "R5", r1 - p, TRP);
        wait_code(K_REF, 20, r2);
        chk(r2 - r1 == TRFC, "R7", r2 - r1, TRFC);
        nref = 2; last = r2; rel = -1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cmd_now() == K_REF) begin nref++; last = cyc; end
            if (!bus_own) begin rel = cyc; break; end
        end
        chk(nref >= DMAX, "R7", nref, DMAX);
        chk(rel - last == TRFC, "R7", rel - last, TRFC);
        chk(debt == 0, "R7", debt, 0);

        // R8, R9, R10: self refresh with an open bank
        step(); bank_open = 4'b0001; sr_req = 1'b1;
        grant_pulse();
        wait_code(K_SRE, 20, p);
        chk(p >= 0, "R8", p, 0);
        repeat (300) @(negedge clk);
        chk(!cke && !rd_ok && debt == 0, "R8", cke, 0);
        step(); sr_req = 1'b0; bank_open = 4'b0000;
        x = -1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cke) begin x = cyc; break; end
        end
        chk(x >= 0 && cs_n, "R9", x, 0);
        rel = -1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!bus_own) begin rel = cyc; break; end
        end
        chk(rel - x == XSNR, "R9", rel - x, XSNR);
        chk(!rd_ok, "R10", rd_ok, 0);
        rd = -1;
        for (int i = 0; i < 400; i++) begin
            if (rd_ok) begin rd = cyc; break; end
            @(negedge clk);
        end
        chk(rd - x == XSRD, "R10", rd - x, XSRD);

        // R8: self refresh with all banks closed goes straight in
        step(); sr_req = 1'b1;
        grant_pulse();
        wait_code(K_SRE, 10, p);
        chk(p >= 0, "R8", p, 0);
        repeat (20) @(negedge clk);
        step(); sr_req = 1'b0;
        repeat (XSRD + 20) @(negedge clk);
        chk(rd_ok && !bus_own, "R10", rd_ok, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule